// File: doc/BRIEF.md
# Sixty-Degree Frame Multilevel Vector Selector

This block is one stage of a multilevel space vector modulator. Its input is a reference vector that has already been folded into the first 60° sector and expressed in the skewed (60°) g-h coordinate system. It also takes the index of the real sector the vector came from. The block locates the triangle of the integer vector lattice that encloses the reference. It computes the three normalized dwell times of the enclosing corners using only adders, subtractors and shifts. It then gives the three-phase level triple of each corner, mapped back to the real sector.

Coordinates arrive as signed fixed-point values with FRAC_W fractional bits. The integer part is the lattice index and the fractional part drives the dwell arithmetic. The reference must be non-negative. Dwell times leave the block as unsigned TIME_W-bit fractions of the modulation period, with all ones meaning one full period. Input and output each use a valid/ready handshake. A result is registered and appears two clock cycles after its input is accepted, as long as the output side is not stalled.

Top module: `svsel_top`

## Requirements
- R1: The base lattice point is g = floor(Vrg), h = floor(Vrh), the integer part of each Q4.12 coordinate. `out_upper` is 0 (lower triangle) when frac(Vrg)+frac(Vrh) ≤ 1, with equality counting as lower, and 1 (upper triangle) otherwise.
- R2: `out_tri` equals 4·s + g + h + 1 for a lower triangle and 4·s + g + h + 2 for an upper triangle, where s is the sector index.
- R3: For a lower triangle, slots 0, 1 and 2 hold the corners (g,h), (g+1,h) and (g,h+1). Their dwell times are 1−fg−fh, fg and fh, where fg and fh are the fractional parts.
- R4: For an upper triangle, slots 0, 1 and 2 hold the corners (g+1,h), (g,h+1) and (g+1,h+1). Their dwell times are 1−fh, 1−fg and fg+fh−1.
- R5: Each dwell time is the Q12 value shifted left by TIME_W−FRAC_W bits. A value of one full period or more saturates to all ones (65535), and a negative value clamps to 0.
- R6: In sector 0, a corner (x,y) has the level triple (A,B,C) = (x+y, y, 0). Each triple is packed {C,B,A}, with phase A in the lowest LVL_W bits.
- R7: In sector 1, the first-sector triple (a,b,0) becomes (a−b, a, 0). For example, (1,0,0) becomes (1,1,0).
- R8: Sectors 2 and 4 rotate the sector-0 triple right by one and two positions. Sectors 3 and 5 do the same to the sector-1 triple. Rotating (A,B,C) right by one gives (C,A,B), and rotating it right by two gives (B,C,A).
- R9: A result appears with `out_valid` high two clock cycles after its input is accepted when `out_ready` stays high. Each accepted input gives exactly one result, and results come out in order.
- R10: While `out_valid` is high and `out_ready` is low, every output stays unchanged. `in_ready` falls once both pipeline stages are occupied, and `in_ready` is high whenever `out_valid` is low.
- R11: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_vg | input | COORD_W | Reference g coordinate, signed Q(COORD_W−FRAC_W).FRAC_W |
| in_vh | input | COORD_W | Reference h coordinate, signed, same format |
| in_sector | input | 3 | Real sector index, 0 to 5 |
| out_ready | input | 1 | Downstream accepts the result |
| out_valid | output | 1 | Result present |
| out_upper | output | 1 | 0 lower triangle, 1 upper triangle |
| out_tri | output | TRI_W | Triangle number |
| out_t0 | output | TIME_W | Dwell time of slot 0 |
| out_t1 | output | TIME_W | Dwell time of slot 1 |
| out_t2 | output | TIME_W | Dwell time of slot 2 |
| out_lvl0 | output | 3·LVL_W | Level triple {C,B,A} of slot 0 |
| out_lvl1 | output | 3·LVL_W | Level triple {C,B,A} of slot 1 |
| out_lvl2 | output | 3·LVL_W | Level triple {C,B,A} of slot 2 |

## Verification
The bench builds the block with its default parameters: COORD_W 16 and FRAC_W 12, which give a Q4.12 coordinate and lattice indices up to 7, and TIME_W 16. With these values the exact lower/upper boundary can be reached, at 1.5 + 0.5, and so can the corner one step above it. A lattice point whose dwell saturates to 65535 is also reachable, and so are triples of all six sectors at several grid levels. The stall, back-to-back and random-ready phases exercise the handshake with both pipeline stages full.

// File: rtl/svsel_pkg.sv
package svsel_pkg;
    localparam int unsigned COORD_W_DEF = 16;
    localparam int unsigned FRAC_W_DEF  = 12;
    localparam int unsigned TIME_W_DEF  = 16;
    localparam int unsigned SLOTS       = 3;
    localparam int unsigned SECTOR_W    = 3;

    typedef enum logic {
        TRI_LOWER = 1'b0,
        TRI_UPPER = 1'b1
    } tri_kind_e;
endpackage

// File: rtl/svsel_locate.sv
module svsel_locate
    import svsel_pkg::*;
#(
    parameter int unsigned COORD_W = COORD_W_DEF,
    parameter int unsigned FRAC_W  = FRAC_W_DEF
) (
    input  logic signed [COORD_W-1:0]        vg,
    input  logic signed [COORD_W-1:0]        vh,
    output logic signed [COORD_W-FRAC_W-1:0] g,
    output logic signed [COORD_W-FRAC_W-1:0] h,
    output logic        [FRAC_W-1:0]         fg,
    output logic        [FRAC_W-1:0]         fh,
    output tri_kind_e                        kind
);
    localparam logic [FRAC_W:0] ONE = (FRAC_W+1)'(1) << FRAC_W;

    logic [FRAC_W:0] frac_sum;

    always_comb begin
        // integer field of a two's complement word is the floor
        g        = vg[COORD_W-1:FRAC_W];
        h        = vh[COORD_W-1:FRAC_W];
        fg       = vg[FRAC_W-1:0];
        fh       = vh[FRAC_W-1:0];
        frac_sum = {1'b0, fg} + {1'b0, fh};
        kind     = (frac_sum > ONE) ? TRI_UPPER : TRI_LOWER;
    end
endmodule

// File: rtl/svsel_dwell.sv
module svsel_dwell
    import svsel_pkg::*;
#(
    parameter int unsigned FRAC_W = FRAC_W_DEF,
    parameter int unsigned TIME_W = TIME_W_DEF
) (
    input  logic [FRAC_W-1:0]             fg,
    input  logic [FRAC_W-1:0]             fh,
    input  tri_kind_e                     kind,
    output logic [SLOTS-1:0][TIME_W-1:0]  t
);
    localparam int unsigned RAW_W = FRAC_W + 3;
    localparam int unsigned SHIFT = TIME_W - FRAC_W;
    localparam logic signed [RAW_W-1:0] ONE = RAW_W'(1) << FRAC_W;

    typedef logic signed [RAW_W-1:0] raw_t;

    function automatic logic [TIME_W-1:0] to_time(input raw_t r);
        logic [TIME_W-1:0] v;
        v = '0;
        if (r < 0) begin
            v = '0;
        end else if (r >= ONE) begin
            v = '1;
        end else begin
            v[TIME_W-1:SHIFT] = r[FRAC_W-1:0];
        end
        return v;
    endfunction

    raw_t fgx, fhx;
    raw_t raw [SLOTS];

    always_comb begin
        fgx = raw_t'({3'b000, fg});
        fhx = raw_t'({3'b000, fh});
        if (kind == TRI_LOWER) begin
            raw[0] = ONE - fgx - fhx;
            raw[1] = fgx;
            raw[2] = fhx;
        end else begin
            raw[0] = ONE - fhx;
            raw[1] = ONE - fgx;
            raw[2] = fgx + fhx - ONE;
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_sat
        assign t[i] = to_time(raw[i]);
    end
endmodule

// File: rtl/svsel_phase.sv
module svsel_phase
    import svsel_pkg::*;
#(
    parameter int unsigned CRD_W = 5,
    parameter int unsigned LVL_W = 6
) (
    input  logic signed [CRD_W-1:0]    x,
    input  logic signed [CRD_W-1:0]    y,
    input  logic        [SECTOR_W-1:0] sector,
    output logic        [3*LVL_W-1:0]  lvl
);
    logic signed [LVL_W-1:0] xe, ye, a, b;
    logic [LVL_W-1:0] pa, pb, pc, ra, rb, rc;

    always_comb begin
        xe = LVL_W'(x);
        ye = LVL_W'(y);
        a  = xe + ye;
        b  = ye;
        // odd sectors mirror the first-sector triple first
        if (sector[0]) begin
            pa = a - b;
            pb = a;
        end else begin
            pa = a;
            pb = b;
        end
        pc = '0;
        unique case (sector[SECTOR_W-1:1])
            2'd1: begin ra = pc; rb = pa; rc = pb; end
            2'd2: begin ra = pb; rb = pc; rc = pa; end
            default: begin ra = pa; rb = pb; rc = pc; end
        endcase
        lvl = {rc, rb, ra};
    end
endmodule

// File: rtl/svsel_top.sv
module svsel_top
    import svsel_pkg::*;
#(
    parameter int unsigned COORD_W = COORD_W_DEF,
    parameter int unsigned FRAC_W  = FRAC_W_DEF,
    parameter int unsigned TIME_W  = TIME_W_DEF,
    localparam int unsigned INT_W  = COORD_W - FRAC_W,
    localparam int unsigned LVL_W  = INT_W + 2,
    localparam int unsigned TRI_W  = INT_W + 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic signed [COORD_W-1:0] in_vg,
    input  logic signed [COORD_W-1:0] in_vh,
    input  logic [SECTOR_W-1:0]       in_sector,
    input  logic                      out_ready,
    output logic                      out_valid,
    output logic                      out_upper,
    output logic [TRI_W-1:0]          out_tri,
    output logic [TIME_W-1:0]         out_t0,
    output logic [TIME_W-1:0]         out_t1,
    output logic [TIME_W-1:0]         out_t2,
    output logic [3*LVL_W-1:0]        out_lvl0,
    output logic [3*LVL_W-1:0]        out_lvl1,
    output logic [3*LVL_W-1:0]        out_lvl2
);
    localparam int unsigned CRD_W = INT_W + 1;

    typedef struct packed {
        logic                     valid;
        tri_kind_e                kind;
        logic signed [INT_W-1:0]  g;
        logic signed [INT_W-1:0]  h;
        logic [FRAC_W-1:0]        fg;
        logic [FRAC_W-1:0]        fh;
        logic [SECTOR_W-1:0]      sector;
    } stage1_t;

    typedef struct packed {
        logic                            valid;
        tri_kind_e                       kind;
        logic [TRI_W-1:0]                tri_n;
        logic [SLOTS-1:0][TIME_W-1:0]    t;
        logic [SLOTS-1:0][3*LVL_W-1:0]   lvl;
    } stage2_t;

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;

    // locate on the raw input
    logic signed [INT_W-1:0] loc_g, loc_h;
    logic [FRAC_W-1:0]       loc_fg, loc_fh;
    tri_kind_e               loc_kind;

    svsel_locate #(.COORD_W(COORD_W), .FRAC_W(FRAC_W)) locate_i (
        .vg   (in_vg),
        .vh   (in_vh),
        .g    (loc_g),
        .h    (loc_h),
        .fg   (loc_fg),
        .fh   (loc_fh),
        .kind (loc_kind)
    );

    // dwell times from the registered fractions
    logic [SLOTS-1:0][TIME_W-1:0] dw_t;

    svsel_dwell #(.FRAC_W(FRAC_W), .TIME_W(TIME_W)) dwell_i (
        .fg   (s1_q.fg),
        .fh   (s1_q.fh),
        .kind (s1_q.kind),
        .t    (dw_t)
    );

    // corner coordinates of each slot
    logic signed [CRD_W-1:0] gx, hx, gx1, hx1;
    logic signed [CRD_W-1:0] slot_x [SLOTS];
    logic signed [CRD_W-1:0] slot_y [SLOTS];
    logic [SLOTS-1:0][3*LVL_W-1:0] ph_lvl;

    always_comb begin
        gx  = CRD_W'(s1_q.g);
        hx  = CRD_W'(s1_q.h);
        gx1 = gx + CRD_W'(1);
        hx1 = hx + CRD_W'(1);
        if (s1_q.kind == TRI_LOWER) begin
            slot_x[0] = gx;  slot_y[0] = hx;
            slot_x[1] = gx1; slot_y[1] = hx;
            slot_x[2] = gx;  slot_y[2] = hx1;
        end else begin
            slot_x[0] = gx1; slot_y[0] = hx;
            slot_x[1] = gx;  slot_y[1] = hx1;
            slot_x[2] = gx1; slot_y[2] = hx1;
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_phase
        svsel_phase #(.CRD_W(CRD_W), .LVL_W(LVL_W)) phase_i (
            .x      (slot_x[i]),
            .y      (slot_y[i]),
            .sector (s1_q.sector),
            .lvl    (ph_lvl[i])
        );
    end

    // triangle number
    logic signed [TRI_W:0] tri_sum;

    always_comb begin
        tri_sum = (TRI_W+1)'({s1_q.sector, 2'b00})
                + (TRI_W+1)'(s1_q.g)
                + (TRI_W+1)'(s1_q.h)
                + ((s1_q.kind == TRI_UPPER) ? (TRI_W+1)'(2) : (TRI_W+1)'(1));
    end

    logic s1_en, s2_en;

    always_comb begin
        s2_en = !s2_q.valid || out_ready;
        s1_en = !s1_q.valid || s2_en;

        s1_d = s1_q;
        if (s1_en) begin
            s1_d.valid = in_valid;
            if (in_valid) begin
                s1_d.kind   = loc_kind;
                s1_d.g      = loc_g;
                s1_d.h      = loc_h;
                s1_d.fg     = loc_fg;
                s1_d.fh     = loc_fh;
                s1_d.sector = in_sector;
            end
        end

        s2_d = s2_q;
        if (s2_en) begin
            s2_d.valid = s1_q.valid;
            if (s1_q.valid) begin
                s2_d.kind  = s1_q.kind;
                s2_d.tri_n = tri_sum[TRI_W-1:0];
                s2_d.t     = dw_t;
                s2_d.lvl   = ph_lvl;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign in_ready  = s1_en;
    assign out_valid = s2_q.valid;
    assign out_upper = (s2_q.kind == TRI_UPPER);
    assign out_tri   = s2_q.tri_n;
    assign out_t0    = s2_q.t[0];
    assign out_t1    = s2_q.t[1];
    assign out_t2    = s2_q.t[2];
    assign out_lvl0  = s2_q.lvl[0];
    assign out_lvl1  = s2_q.lvl[1];
    assign out_lvl2  = s2_q.lvl[2];
endmodule

// File: rtl/svsel_chk.sv
module svsel_chk #(
    parameter int unsigned TIME_W = 16,
    parameter int unsigned LVL_W  = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_ready,
    input logic                 out_valid,
    input logic [TIME_W-1:0]    out_t0,
    input logic [TIME_W-1:0]    out_t1,
    input logic [TIME_W-1:0]    out_t2,
    input logic [3*LVL_W-1:0]   out_lvl0,
    input logic [3*LVL_W-1:0]   out_lvl1,
    input logic [3*LVL_W-1:0]   out_lvl2
);
    localparam logic [TIME_W+1:0] FULL = (TIME_W+2)'(1) << TIME_W;

    function automatic logic has_zero(input logic [3*LVL_W-1:0] v);
        return (v[LVL_W-1:0] == '0) || (v[2*LVL_W-1:LVL_W] == '0)
            || (v[3*LVL_W-1:2*LVL_W] == '0);
    endfunction

    logic [TIME_W+1:0] t_sum;
    assign t_sum = (TIME_W+2)'(out_t0) + (TIME_W+2)'(out_t1) + (TIME_W+2)'(out_t2);

    // R11: reset state
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r11: assert (!out_valid && in_ready);
        end
    end

    // R3 / R4 / R5: dwell times cover one period, less at most one saturation step
    p_period_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (t_sum <= FULL) && (t_sum >= FULL - 1));

    // R6 / R7 / R8: every level triple keeps one phase at level zero
    p_zero_phase0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> has_zero(out_lvl0));
    p_zero_phase1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> has_zero(out_lvl1));
    p_zero_phase2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> has_zero(out_lvl2));

    // R9: a fresh result follows an accepted input by two cycles
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready, 2));

    // R10: stalled output holds
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_t0) && $stable(out_t1)
            && $stable(out_t2) && $stable(out_lvl0) && $stable(out_lvl1) && $stable(out_lvl2));

    // R10: empty output stage always accepts
    p_ready_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
endmodule

bind svsel_top svsel_chk #(.TIME_W(TIME_W), .LVL_W(LVL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_t0    (out_t0),
    .out_t1    (out_t1),
    .out_t2    (out_t2),
    .out_lvl0  (out_lvl0),
    .out_lvl1  (out_lvl1),
    .out_lvl2  (out_lvl2)
);

// File: tb/svsel_top_tb_top.sv
module svsel_top_tb_top;
    localparam int COORD_W = 16;
    localparam int FRAC_W  = 12;
    localparam int TIME_W  = 16;
    localparam int LVL_W   = COORD_W - FRAC_W + 2;
    localparam int TRI_W   = COORD_W - FRAC_W + 4;
    localparam int ONE     = 1 << FRAC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [COORD_W-1:0] in_vg = '0;
    logic signed [COORD_W-1:0] in_vh = '0;
    logic [2:0] in_sector = '0;
    logic out_ready = 1'b1;
    logic out_valid, out_upper;
    logic [TRI_W-1:0] out_tri;
    logic [TIME_W-1:0] out_t0, out_t1, out_t2;
    logic [3*LVL_W-1:0] out_lvl0, out_lvl1, out_lvl2;

    always #4 clk = ~clk;

    svsel_top #(.COORD_W(COORD_W), .FRAC_W(FRAC_W), .TIME_W(TIME_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_vg(in_vg), .in_vh(in_vh), .in_sector(in_sector), .out_ready(out_ready),
        .out_valid(out_valid), .out_upper(out_upper), .out_tri(out_tri),
        .out_t0(out_t0), .out_t1(out_t1), .out_t2(out_t2),
        .out_lvl0(out_lvl0), .out_lvl1(out_lvl1), .out_lvl2(out_lvl2)
    );

    typedef struct {
        int sector;
        logic upper;
        int tri_n;
        int t [3];
        logic [3*LVL_W-1:0] lvl [3];
        int stamp;
        bit lat;
    } exp_t;

    exp_t q [$];
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rdy_mode = 0;
    logic [7:0] lfsr = 8'hA5;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic int to_time(input int r);
        if (r < 0) return 0;
        if (r >= ONE) return (1 << TIME_W) - 1;
        return r << (TIME_W - FRAC_W);
    endfunction

    function automatic logic [3*LVL_W-1:0] triple(input int x, input int y, input int s);
        int a, b, pa, pb, pc, ra, rb, rc;
        logic [LVL_W-1:0] la, lb, lc;
        a = x + y; b = y;
        if (s % 2 == 1) begin pa = a - b; pb = a; end
        else begin pa = a; pb = b; end
        pc = 0;
        case (s / 2)
            1: begin ra = pc; rb = pa; rc = pb; end
            2: begin ra = pb; rb = pc; rc = pa; end
            default: begin ra = pa; rb = pb; rc = pc; end
        endcase
        la = LVL_W'(ra); lb = LVL_W'(rb); lc = LVL_W'(rc);
        return {lc, lb, la};
    endfunction

    function automatic exp_t model(input int vg, input int vh, input int s);
        exp_t e;
        int g, h, fg, fh;
        g = vg / ONE; h = vh / ONE;
        fg = vg - g * ONE; fh = vh - h * ONE;
        e.sector = s;
        e.upper = (fg + fh > ONE);
        e.tri_n = 4 * s + g + h + (e.upper ? 2 : 1);
        if (!e.upper) begin
            e.t[0] = to_time(ONE - fg - fh); e.t[1] = to_time(fg); e.t[2] = to_time(fh);
            e.lvl[0] = triple(g, h, s);
            e.lvl[1] = triple(g + 1, h, s);
            e.lvl[2] = triple(g, h + 1, s);
        end else begin
            e.t[0] = to_time(ONE - fh); e.t[1] = to_time(ONE - fg); e.t[2] = to_time(fg + fh - ONE);
            e.lvl[0] = triple(g + 1, h, s);
            e.lvl[1] = triple(g, h + 1, s);
            e.lvl[2] = triple(g + 1, h + 1, s);
        end
        e.stamp = 0;
        e.lat = 1'b0;
        return e;
    endfunction

    task automatic send(input int vg, input int vh, input int s, input bit lat);
        exp_t e;
        e = model(vg, vh, s);
        in_valid = 1'b1;
        in_vg = COORD_W'(vg);
        in_vh = COORD_W'(vh);
        in_sector = 3'(s);
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        e.stamp = cyc + 2;
        e.lat = lat;
        q.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // output ready driver
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rdy_mode)
            1: out_ready <= 1'b0;
            2: out_ready <= lfsr[0] | lfsr[3];
            default: out_ready <= 1'b1;
        endcase
    end

    // monitor / scoreboard
    always begin
        @(negedge clk);
        #2;
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R9 unexpected result", 1, 0);
            end else begin
                exp_t e;
                string lreq;
                e = q[0];
                if (e.sector == 0) lreq = "R6 levels";
                else if (e.sector == 1) lreq = "R7 levels";
                else lreq = "R8 levels";
                check(out_upper == e.upper, "R1 triangle half", out_upper, e.upper);
                check(int'(out_tri) == e.tri_n, "R2 triangle number", out_tri, e.tri_n);
                check(int'(out_t0) == e.t[0], e.t[0] == 65535 ? "R5 dwell slot0" : (e.upper ? "R4 dwell slot0" : "R3 dwell slot0"), out_t0, e.t[0]);
                check(int'(out_t1) == e.t[1], e.upper ? "R4 dwell slot1" : "R3 dwell slot1", out_t1, e.t[1]);
                check(int'(out_t2) == e.t[2], e.upper ? "R4 dwell slot2" : "R3 dwell slot2", out_t2, e.t[2]);
                check(out_lvl0 == e.lvl[0], lreq, out_lvl0, e.lvl[0]);
                check(out_lvl1 == e.lvl[1], lreq, out_lvl1, e.lvl[1]);
                check(out_lvl2 == e.lvl[2], lreq, out_lvl2, e.lvl[2]);
                if (out_ready) begin
                    if (e.lat) check(cyc == e.stamp, "R9 latency", cyc, e.stamp);
                    void'(q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) begin
            @(negedge clk);
            #1;
            check(out_valid == 1'b0, "R11 out_valid in reset", out_valid, 0);
            check(in_ready == 1'b1, "R11 in_ready in reset", in_ready, 1);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R6 reference point: 1.236, 0.335 in sector 0 gives (1,0,0),(2,0,0),(2,1,0)
        send(5063, 1372, 0, 1'b1);
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R9 single result drained", q.size(), 0);
        check(triple(1, 0, 0) == {6'd0, 6'd0, 6'd1} && triple(2, 1 - 1, 0) == {6'd0, 6'd0, 6'd2}
              && triple(1, 1, 0) == {6'd0, 6'd1, 6'd2}, "R6 model triples", 0, 0);
        // R7 example values: (1,0,0)->(1,1,0), (2,2,0)->(0,2,0)
        check(triple(1, 0, 1) == {6'd0, 6'd1, 6'd1}, "R7 example one", triple(1, 0, 1), {6'd0, 6'd1, 6'd1});
        check(triple(0, 2, 1) == {6'd0, 6'd2, 6'd0}, "R7 example two", triple(0, 2, 1), {6'd0, 6'd2, 6'd0});

        // R1 boundary: 1.5 + 0.5 is lower, one step more is upper
        send(32'h1800, 32'h0800, 0, 1'b1);
        send(32'h1800, 32'h0801, 0, 1'b1);
        // R5 saturation at a lattice point, and near-zero corners
        send(32'h2000, 32'h0000, 0, 1'b1);
        send(32'h0000, 32'h0000, 0, 1'b1);
        send(32'h1FFF, 32'h0FFF, 3, 1'b1);
        // R7 R8: every sector, both halves
        for (int s = 0; s < 6; s++) begin
            send(32'h0B33, 32'h0999, s, 1'b1);
            send(32'h1266, 32'h0400, s, 1'b1);
        end
        // sweep, back to back
        for (int i = 0; i < 60; i++) begin
            send((i * 1237 + 311) % 14000, (i * 2719 + 97) % 13000, i % 6, 1'b1);
        end
        repeat (4) @(negedge clk);

        // R10: stall with both stages full
        rdy_mode = 1;
        @(negedge clk);
        send(32'h1400, 32'h0300, 2, 1'b0);
        send(32'h0A00, 32'h0C00, 5, 1'b0);
        #1;
        check(in_ready == 1'b0, "R10 in_ready low when full", in_ready, 0);
        repeat (4) @(negedge clk);
        #1;
        check(in_ready == 1'b0, "R10 in_ready held low", in_ready, 0);
        check(out_valid == 1'b1, "R10 out_valid held", out_valid, 1);
        check(q.size() == 2, "R10 nothing consumed while stalled", q.size(), 2);
        rdy_mode = 0;
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R10 drained after release", q.size(), 0);

        // random ready pattern
        rdy_mode = 2;
        for (int i = 0; i < 40; i++) begin
            send((i * 3331 + 77) % 15000, (i * 1999 + 500) % 12000, (i * 5) % 6, 1'b0);
        end
        rdy_mode = 0;
        for (int i = 0; i < 50 && q.size() != 0; i++) @(negedge clk);
        check(q.size() == 0, "R9 all results delivered", q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule